// File: doc/BRIEF.md
# SATA Out-of-Band Transmit Sequencer

This block produces the transmit side of SATA out-of-band signalling for a serial transceiver whose parallel side runs at 150 MHz, or about 6.67 ns per cycle. A one-cycle pulse on one of three request inputs starts a pattern. The block then sends a fixed number of bursts. During a burst it drives a repeating D10.2 data word with the valid flag set. Between bursts it holds the line in electrical idle for a gap. The three patterns (COMINIT/COMRESET, COMWAKE, COMSAS) share one burst engine. They differ only in how long each gap lasts.

After the trailing gap of the last burst, the block raises a one-cycle completion strobe. It then waits for the next request. A separate force-idle input keeps the line in electrical idle whatever the sequencer is doing. The link-layer state machine uses this input to silence the transmitter.

Top module: `oob_tx_seq`

## Requirements
- R1: A request held high for a single sampled clock edge starts a complete pattern of BURSTS bursts, each followed by one gap, with no further input needed.
- R2: In the BURST_LEN cycles that follow the accepting edge, and at the start of each later burst, data_valid_o is 1, elec_idle_o is 0 and data_o equals BURST_WORD (default 20'h55555, the D10.2 bit pattern).
- R3: During every gap, elec_idle_o is 1, data_valid_o is 0 and data_o is 0.
- R4: The gap lasts GAP_INIT cycles for an init request, GAP_WAKE cycles for a wake request and GAP_SAS cycles for a SAS request. Burst length and burst count are the same for all three patterns.
- R5: done_o is 1 for exactly one cycle: the cycle right after the final cycle of the last gap. In that cycle the outputs are idle.
- R6: A request is ignored while a pattern is being sent, and also in the cycle in which done_o is high. Requests are accepted again from the cycle after the strobe.
- R7: When requests arrive together, init wins over wake and wake wins over SAS.
- R8: While force_idle_i is 1, elec_idle_o is 1, data_valid_o is 0 and data_o is 0 in the same cycle, whatever the sequencer state. The timing of the sequence and of done_o does not change.
- R9: After reset, and while no pattern is running, elec_idle_o is 1, data_valid_o is 0, data_o is 0 and done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel transceiver clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_init_i | input | 1 | COMINIT/COMRESET request strobe |
| req_wake_i | input | 1 | COMWAKE request strobe |
| req_sas_i | input | 1 | COMSAS request strobe |
| force_idle_i | input | 1 | Forces electrical idle on the line |
| data_o | output | DATA_W | Parallel word to the serialiser |
| data_valid_o | output | 1 | Data word is being transmitted |
| elec_idle_o | output | 1 | Electrical-idle control to the line driver |
| done_o | output | 1 | One-cycle pattern completion strobe |

## Verification
The bench builds the block with BURSTS=3, BURST_LEN=4, GAP_INIT=6, GAP_WAKE=2 and GAP_SAS=11. Every pattern therefore runs in a few dozen cycles, so the bench can compare the whole waveform cycle by cycle. The three gaps are all different, so a pattern given the wrong gap, or the wrong winner when requests collide, shows up as a shifted burst edge. Because the burst count is small, the bench can also reach the boundary around the completion strobe: a request in the strobe cycle, and one in the cycle after it.

// File: rtl/oob_tx_pkg.sv
package oob_tx_pkg;
  typedef enum logic [1:0] {PAT_NONE, PAT_INIT, PAT_WAKE, PAT_SAS} oob_pat_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_GAP} oob_st_e;
endpackage

// File: rtl/oob_req_arb.sv
module oob_req_arb
  import oob_tx_pkg::*;
(
  input  logic     req_init_i,
  input  logic     req_wake_i,
  input  logic     req_sas_i,
  input  logic     ready_i,
  output logic     start_o,
  output oob_pat_e pat_o
);
  always_comb begin
    if (req_init_i)      pat_o = PAT_INIT;
    else if (req_wake_i) pat_o = PAT_WAKE;
    else if (req_sas_i)  pat_o = PAT_SAS;
    else                 pat_o = PAT_NONE;
  end

  assign start_o = ready_i && (pat_o != PAT_NONE);
endmodule

// File: rtl/oob_burst_seq.sv
module oob_burst_seq
  import oob_tx_pkg::*;
#(
  parameter int BURSTS    = 6,
  parameter int BURST_LEN = 16,
  parameter int GAP_INIT  = 48,
  parameter int GAP_WAKE  = 16,
  parameter int GAP_SAS   = 144
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  oob_pat_e pat_i,
  output logic     ready_o,
  output logic     burst_o,
  output logic     done_o
);
  localparam int MAX_GAP = (GAP_SAS > GAP_INIT) ?
                           ((GAP_SAS > GAP_WAKE) ? GAP_SAS : GAP_WAKE) :
                           ((GAP_INIT > GAP_WAKE) ? GAP_INIT : GAP_WAKE);
  localparam int MAX_LEN = (MAX_GAP > BURST_LEN) ? MAX_GAP : BURST_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int IDX_W   = $clog2(BURSTS + 1);

  oob_st_e            state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   gap_q;
  logic [IDX_W-1:0]   idx_q;
  logic               done_q;

  function automatic logic [CNT_W-1:0] gap_of(oob_pat_e p);
    case (p)
      PAT_WAKE: gap_of = CNT_W'(GAP_WAKE);
      PAT_SAS:  gap_of = CNT_W'(GAP_SAS);
      default:  gap_of = CNT_W'(GAP_INIT);
    endcase
  endfunction

  wire burst_end = (cnt_q == CNT_W'(BURST_LEN - 1));
  wire gap_end   = (cnt_q == gap_q - CNT_W'(1));
  wire last_one  = (idx_q == IDX_W'(BURSTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_BURST;
          cnt_q   <= '0;
          idx_q   <= '0;
          gap_q   <= gap_of(pat_i);
        end
        ST_BURST: begin
          if (burst_end) begin
            state_q <= ST_GAP;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_GAP: begin
          if (gap_end) begin
            cnt_q <= '0;
            if (last_one) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= ST_BURST;
            end
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // strobe cycle still blocks new requests
  assign ready_o = (state_q == ST_IDLE) && !done_q;
  assign burst_o = (state_q == ST_BURST);
  assign done_o  = done_q;

  a_r2_burst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST) |-> (cnt_q < CNT_W'(BURST_LEN)));
  a_r6_pattern_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(gap_q));
  a_r5_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(state_q == ST_GAP && last_one));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/oob_line_drv.sv
module oob_line_drv #(
  parameter int              DATA_W     = 20,
  parameter logic [DATA_W-1:0] BURST_WORD = '0
) (
  input  logic              burst_i,
  input  logic              force_idle_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              elec_idle_o
);
  wire send = burst_i && !force_idle_i;

  assign data_o       = send ? BURST_WORD : '0;
  assign data_valid_o = send;
  assign elec_idle_o  = !send;
endmodule

// File: rtl/oob_tx_seq.sv
module oob_tx_seq
  import oob_tx_pkg::*;
#(
  parameter int                DATA_W     = 20,
  parameter logic [DATA_W-1:0] BURST_WORD = DATA_W'(20'h55555),
  parameter int                BURSTS     = 6,
  parameter int                BURST_LEN  = 16,
  parameter int                GAP_INIT   = 48,
  parameter int                GAP_WAKE   = 16,
  parameter int                GAP_SAS    = 144
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_init_i,
  input  logic              req_wake_i,
  input  logic              req_sas_i,
  input  logic              force_idle_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              elec_idle_o,
  output logic              done_o
);
  logic     ready, start, burst;
  oob_pat_e pat;

  oob_req_arb u_arb (
    .req_init_i (req_init_i),
    .req_wake_i (req_wake_i),
    .req_sas_i  (req_sas_i),
    .ready_i    (ready),
    .start_o    (start),
    .pat_o      (pat)
  );

  oob_burst_seq #(
    .BURSTS    (BURSTS),
    .BURST_LEN (BURST_LEN),
    .GAP_INIT  (GAP_INIT),
    .GAP_WAKE  (GAP_WAKE),
    .GAP_SAS   (GAP_SAS)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .pat_i   (pat),
    .ready_o (ready),
    .burst_o (burst),
    .done_o  (done_o)
  );

  oob_line_drv #(
    .DATA_W     (DATA_W),
    .BURST_WORD (BURST_WORD)
  ) u_drv (
    .burst_i      (burst),
    .force_idle_i (force_idle_i),
    .data_o       (data_o),
    .data_valid_o (data_valid_o),
    .elec_idle_o  (elec_idle_o)
  );

  a_r8_force_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_idle_i |-> (elec_idle_o && !data_valid_o && data_o == '0));
  a_r3_valid_not_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> !elec_idle_o);
  a_r5_done_line_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (elec_idle_o && !data_valid_o));
endmodule

// File: tb/oob_tx_seq_test.sv
module oob_tx_seq_test;
  localparam int DW = 20;
  localparam logic [DW-1:0] WORD = 20'h55555;
  localparam int NB = 3, BL = 4, G_INIT = 6, G_WAKE = 2, G_SAS = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_init = 0, req_wake = 0, req_sas = 0, force_idle = 0;
  logic [DW-1:0] data;
  logic valid, eidle, done;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  oob_tx_seq #(
    .DATA_W(DW), .BURST_WORD(WORD), .BURSTS(NB), .BURST_LEN(BL),
    .GAP_INIT(G_INIT), .GAP_WAKE(G_WAKE), .GAP_SAS(G_SAS)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_init_i(req_init), .req_wake_i(req_wake),
    .req_sas_i(req_sas), .force_idle_i(force_idle), .data_o(data),
    .data_valid_o(valid), .elec_idle_o(eidle), .done_o(done)
  );

  task automatic check(string req, logic [DW+2:0] act, logic [DW+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic fire(logic i, logic w, logic s);
    @(negedge clk);
    req_init = i; req_wake = w; req_sas = s;
    @(posedge clk); #1;
    req_init = 0; req_wake = 0; req_sas = 0;
  endtask

  // follows one pattern cycle by cycle; k=0 is the cycle after the accepting edge
  task automatic watch(string req, int gap, int f_lo, int f_hi, int inj);
    int total = NB * (BL + gap);
    for (int k = 0; k <= total + 2; k++) begin
      logic b, d;
      @(negedge clk);
      force_idle = (k >= f_lo && k <= f_hi);
      req_wake   = (k == inj);
      req_sas    = (k == inj);
      #1;
      b = (k < total) && ((k % (BL + gap)) < BL) && !force_idle;
      d = (k == total);
      check(req, {data, valid, eidle, done},
            {b ? WORD : {DW{1'b0}}, b, !b, d});
    end
    @(negedge clk);
    force_idle = 0; req_wake = 0; req_sas = 0;
  endtask

  task automatic t_reset();
    check("R9 reset", {data, valid, eidle, done}, {{DW{1'b0}}, 3'b010});
  endtask

  task automatic t_patterns();
    fire(1, 0, 0); watch("R1 R2 R3 R4 R5 init", G_INIT, -1, -1, -1);
    fire(0, 1, 0); watch("R4 wake", G_WAKE, -1, -1, -1);
    fire(0, 0, 1); watch("R4 sas", G_SAS, -1, -1, -1);
  endtask

  task automatic t_busy_ignore();
    // wake+sas injected mid-burst, in a gap, and in the strobe cycle
    fire(1, 0, 0); watch("R6 mid", G_INIT, -1, -1, 2);
    fire(1, 0, 0); watch("R6 gap", G_INIT, -1, -1, BL + 1);
    fire(1, 0, 0); watch("R6 strobe", G_INIT, -1, -1, NB * (BL + G_INIT));
    // a request in the cycle right after the strobe is accepted
    fire(0, 1, 0);
    for (int k = 0; k < NB * (BL + G_WAKE); k++) @(negedge clk);
    @(negedge clk); #1;
    check("R6 done wake", {31'b0, done}, 32'd1);
    fire(0, 0, 1); watch("R6 after strobe", G_SAS, -1, -1, -1);
  endtask

  task automatic t_priority();
    fire(1, 1, 1); watch("R7 init wins", G_INIT, -1, -1, -1);
    fire(0, 1, 1); watch("R7 wake wins", G_WAKE, -1, -1, -1);
  endtask

  task automatic t_force();
    fire(0, 1, 0); watch("R8 force mid", G_WAKE, 1, 7, -1);
    fire(0, 0, 1); watch("R8 force all", G_SAS, 0, 60, -1);
    @(negedge clk); force_idle = 1; #1;
    check("R8 idle forced", {data, valid, eidle, done}, {{DW{1'b0}}, 3'b010});
    force_idle = 0;
  endtask

  initial begin
    #1; t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1; check("R9 idle", {data, valid, eidle, done}, {{DW{1'b0}}, 3'b010});
    t_patterns();
    t_busy_ignore();
    t_priority();
    t_force();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule